// File: doc/BRIEF.md
# Memory window address translator

This block sits between a host memory bus and a removable-card socket and decides, for every host memory cycle, whether the address falls inside one of several programmable memory windows. Each window describes a contiguous range of 4 KB host pages by an inclusive first page and last page. For a hit, the block adds the window's page offset to the host page to form the card-side address. The low twelve address bits pass through unchanged.

Each window also carries per-window cycle attributes: 16-bit data width, zero wait states, a two-bit wait-state count, attribute space versus common space, and write protection. The block reports all of these with the hit. A write that lands in a protected window is still reported as a hit, but it is flagged as blocked and no card write enable is produced. The window settings arrive as a flat byte image with eight bytes per window, together with a per-window enable vector. Results are registered and appear one clock after the cycle is presented.

Top module: `memwin_xlate`

## Requirements
- R1: With cycle valid high, a window hits when its enable bit is set and start page <= host_addr[23:12] <= end page. Both bounds are inclusive. The start page is byte 1 bits 3:0 (high) with byte 0 (low), and the end page is byte 3 bits 3:0 with byte 2. Byte k of window w is win_image[(w*8+k)*8 +: 8].
- R2: On a hit, card_addr[25:12] = host page + offset page, taken modulo 2^14, and card_addr[11:0] = host_addr[11:0]. The offset page is byte 5 bits 3:0 with byte 4.
- R3: When several windows hit, the lowest-numbered one is chosen, and win_idx reports its number.
- R4: On a hit, the block reports these attributes of the chosen window: data16 = byte 1 bit 7, zero_ws = byte 1 bit 6, wait_cnt = byte 3 bits 7:6, and attr_sp = byte 5 bit 6.
- R5: Write protection is byte 5 bit 7. A write that hits a protected window gives hit=1, wr_blk=1 and card_we=0. A write that hits an unprotected window gives card_we=1 and wr_blk=0. A read never asserts either signal.
- R6: A valid cycle that hits no window gives out_vld=1 with hit, win_idx, card_addr, all attributes, wr_blk and card_we at zero.
- R7: The results for a cycle presented with cyc_vld high appear one clock later with out_vld=1. A clock without cyc_vld gives out_vld=0 and all-zero outputs in the next cycle.
- R8: While rst is high at a clock edge, all outputs are zero after that edge.
- R9: A window whose enable bit is clear never hits, even when the address lies in its range. Bits 5:4 of bytes 1, 3 and 5, and bytes 6 and 7, have no effect.
- R10: A window whose start page is greater than its end page never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_vld | input | 1 | Host memory cycle present this clock |
| host_addr | input | 24 | Host byte address |
| host_wr | input | 1 | 1 = write, 0 = read |
| win_en | input | NUM_WIN | Per-window enable, bit 0 = window 0 |
| win_image | input | NUM_WIN*64 | Window setting bytes, eight per window |
| out_vld | output | 1 | Result valid |
| hit | output | 1 | Cycle hit a window |
| win_idx | output | IDX_W | Number of the chosen window |
| card_addr | output | 26 | Translated card address |
| data16 | output | 1 | 16-bit data width |
| zero_ws | output | 1 | Zero wait states |
| wait_cnt | output | 2 | Wait-state count |
| attr_sp | output | 1 | Attribute space selected |
| wr_blk | output | 1 | Write blocked by protection |
| card_we | output | 1 | Card write enable |

## Verification
Every result is due exactly one clock after the cycle that caused it, because one output register follows a purely combinational decode. The bench changes inputs only on falling edges. It pushes the expected result for each presented cycle into a queue at the moment it drives that cycle. A monitor, also on falling edges, pops and compares one entry whenever out_vld is high, and checks for all-zero outputs whenever out_vld is low. Window settings change only after a falling edge with cyc_vld low, so no cycle that is still waiting for its rising edge sees the new settings.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    parameter int unsigned HOST_AW     = 24;
    parameter int unsigned PAGE_SHIFT  = 12;
    parameter int unsigned PAGE_W      = HOST_AW - PAGE_SHIFT;
    parameter int unsigned CARD_PG_W   = PAGE_W + 2;
    parameter int unsigned CARD_AW     = CARD_PG_W + PAGE_SHIFT;
    parameter int unsigned WIN_BYTES   = 8;
    parameter int unsigned WIN_BITS    = WIN_BYTES * 8;

    typedef logic [PAGE_W-1:0]    page_t;
    typedef logic [CARD_PG_W-1:0] cpage_t;

    typedef struct packed {
        logic       data16;
        logic       zero_ws;
        logic [1:0] wait_cnt;
        logic       attr_sp;
    } cyc_attr_t;

    typedef struct packed {
        page_t     first_pg;
        page_t     last_pg;
        page_t     shift_pg;
        cyc_attr_t attr;
        logic      wr_prot;
    } win_cfg_t;

    typedef struct packed {
        logic                 hit;
        logic [CARD_AW-1:0]   card_addr;
        cyc_attr_t            attr;
        logic                 wr_blk;
        logic                 card_we;
    } xlate_res_t;

    // Pull one window's fields out of its eight-byte group.
    function automatic win_cfg_t unpack_window(input logic [WIN_BITS-1:0] grp);
        win_cfg_t c;
        c.first_pg      = {grp[11:8],  grp[7:0]};
        c.last_pg       = {grp[27:24], grp[23:16]};
        c.shift_pg      = {grp[43:40], grp[39:32]};
        c.attr.data16   = grp[15];
        c.attr.zero_ws  = grp[14];
        c.attr.wait_cnt = grp[31:30];
        c.attr.attr_sp  = grp[46];
        c.wr_prot       = grp[47];
        return c;
    endfunction

    // Card page: host page plus window offset, wrapping at the card page width.
    function automatic cpage_t add_pages(input page_t host_pg, input page_t off_pg);
        return cpage_t'({{(CARD_PG_W-PAGE_W){1'b0}}, host_pg}
                      + {{(CARD_PG_W-PAGE_W){1'b0}}, off_pg});
    endfunction

endpackage

// File: rtl/memwin_cfg_unpack.sv
module memwin_cfg_unpack
    import memwin_pkg::*;
#(
    parameter int unsigned NUM_WIN = 5
) (
    input  logic [NUM_WIN*WIN_BITS-1:0] win_image,
    output win_cfg_t [NUM_WIN-1:0]      cfg
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign cfg[w] = unpack_window(win_image[w*WIN_BITS +: WIN_BITS]);
    end

endmodule

// File: rtl/memwin_match.sv
module memwin_match
    import memwin_pkg::*;
#(
    parameter int unsigned NUM_WIN = 5
) (
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic [NUM_WIN-1:0]     win_en,
    input  page_t                  host_pg,
    output logic [NUM_WIN-1:0]     in_range,
    output cpage_t [NUM_WIN-1:0]   card_pg
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic above_first;
        logic below_last;
        assign above_first = (host_pg >= cfg[w].first_pg);
        assign below_last  = (host_pg <= cfg[w].last_pg);
        assign in_range[w] = win_en[w] & above_first & below_last;
        assign card_pg[w]  = add_pages(host_pg, cfg[w].shift_pg);
    end

endmodule

// File: rtl/memwin_prio.sv
module memwin_prio #(
    parameter int unsigned NUM_WIN = 5,
    localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] req,
    output logic [NUM_WIN-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (req[w]) begin
                grant    = '0;
                grant[w] = 1'b1;
                idx      = IDX_W'(w);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/memwin_xlate.sv
module memwin_xlate
    import memwin_pkg::*;
#(
    parameter int unsigned NUM_WIN = 5,
    localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cyc_vld,
    input  logic [HOST_AW-1:0]          host_addr,
    input  logic                        host_wr,
    input  logic [NUM_WIN-1:0]          win_en,
    input  logic [NUM_WIN*WIN_BITS-1:0] win_image,
    output logic                        out_vld,
    output logic                        hit,
    output logic [IDX_W-1:0]            win_idx,
    output logic [CARD_AW-1:0]          card_addr,
    output logic                        data16,
    output logic                        zero_ws,
    output logic [1:0]                  wait_cnt,
    output logic                        attr_sp,
    output logic                        wr_blk,
    output logic                        card_we
);

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     in_range;
    cpage_t [NUM_WIN-1:0]   card_pg;
    logic [NUM_WIN-1:0]     grant;
    logic [IDX_W-1:0]       sel_idx;
    logic                   any_hit;
    page_t                  host_pg;

    assign host_pg = host_addr[HOST_AW-1:PAGE_SHIFT];

    memwin_cfg_unpack #(.NUM_WIN(NUM_WIN)) u_unpack (
        .win_image (win_image),
        .cfg       (cfg)
    );

    memwin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg      (cfg),
        .win_en   (win_en),
        .host_pg  (host_pg),
        .in_range (in_range),
        .card_pg  (card_pg)
    );

    memwin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .req   (in_range),
        .grant (grant),
        .idx   (sel_idx),
        .any   (any_hit)
    );

    // One-hot AND-OR select of the winning window's page and flags.
    xlate_res_t res_d;
    cpage_t     sel_pg;
    cyc_attr_t  sel_attr;
    logic       sel_wp;

    always_comb begin
        sel_pg   = '0;
        sel_attr = '0;
        sel_wp   = 1'b0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (grant[w]) begin
                sel_pg   = sel_pg   | card_pg[w];
                sel_attr = sel_attr | cfg[w].attr;
                sel_wp   = sel_wp   | cfg[w].wr_prot;
            end
        end
        res_d           = '0;
        res_d.hit       = cyc_vld & any_hit;
        if (res_d.hit) begin
            res_d.card_addr = {sel_pg, host_addr[PAGE_SHIFT-1:0]};
            res_d.attr      = sel_attr;
            res_d.wr_blk    = host_wr & sel_wp;
            res_d.card_we   = host_wr & ~sel_wp;
        end
    end

    xlate_res_t       res_q;
    logic [IDX_W-1:0] idx_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            idx_q <= '0;
            res_q <= '0;
        end else begin
            vld_q <= cyc_vld;
            idx_q <= (cyc_vld & any_hit) ? sel_idx : '0;
            res_q <= res_d;
        end
    end

    assign out_vld   = vld_q;
    assign hit       = res_q.hit;
    assign win_idx   = idx_q;
    assign card_addr = res_q.card_addr;
    assign data16    = res_q.attr.data16;
    assign zero_ws   = res_q.attr.zero_ws;
    assign wait_cnt  = res_q.attr.wait_cnt;
    assign attr_sp   = res_q.attr.attr_sp;
    assign wr_blk    = res_q.wr_blk;
    assign card_we   = res_q.card_we;

    // R7: a presented cycle yields a result on the next clock
    a_r7_result_next: assert property (@(posedge clk) disable iff (rst)
        cyc_vld |=> out_vld);

    // R7: an idle clock yields no result and no hit
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cyc_vld |=> (!out_vld && !hit && !card_we));

    // R8: reset clears the result
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_vld && !hit && !wr_blk && !card_we));

    // R5: blocked and enabled writes never coincide, and both need a hit
    a_r5_we_blk_excl: assert property (@(posedge clk) disable iff (rst)
        (card_we || wr_blk) |-> (hit && !(card_we && wr_blk)));

    // R5: a read never produces a card write or a block
    a_r5_read_quiet: assert property (@(posedge clk) disable iff (rst)
        (cyc_vld && !host_wr) |=> (!card_we && !wr_blk));

    // R2: page-internal address bits pass straight through
    a_r2_low_bits: assert property (@(posedge clk) disable iff (rst)
        (cyc_vld && any_hit) |=> (card_addr[PAGE_SHIFT-1:0] == $past(host_addr[PAGE_SHIFT-1:0])));

    // R6: a miss leaves address and window number at zero
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !hit) |-> (card_addr == '0 && win_idx == '0 && wait_cnt == 2'b00));

    // R3: the reported window number is always a real window
    a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
        hit |-> (32'(win_idx) < NUM_WIN));

endmodule

// File: tb/memwin_xlate_test.sv
`timescale 1ns/1ps
module memwin_xlate_test;

    localparam int NW = 5;
    localparam int NB = NW * 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_vld;
    logic [23:0] host_addr;
    logic        host_wr;
    logic [NW-1:0]     win_en;
    logic [NW*64-1:0]  win_image;
    logic [7:0]  img [NB];

    logic        out_vld, hit, data16, zero_ws, attr_sp, wr_blk, card_we;
    logic [2:0]  win_idx;
    logic [25:0] card_addr;
    logic [1:0]  wait_cnt;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NB; i++) win_image[i*8 +: 8] = img[i];
    end

    memwin_xlate #(.NUM_WIN(NW)) uut (
        .clk(clk), .rst(rst), .cyc_vld(cyc_vld), .host_addr(host_addr),
        .host_wr(host_wr), .win_en(win_en), .win_image(win_image),
        .out_vld(out_vld), .hit(hit), .win_idx(win_idx), .card_addr(card_addr),
        .data16(data16), .zero_ws(zero_ws), .wait_cnt(wait_cnt),
        .attr_sp(attr_sp), .wr_blk(wr_blk), .card_we(card_we)
    );

    typedef struct { logic [36:0] v; string tag; } item_t;
    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    logic mon_on = 1'b0;

    function automatic logic [36:0] actual();
        return {hit, win_idx, card_addr, data16, zero_ws, wait_cnt, attr_sp, wr_blk, card_we};
    endfunction

    // Reference model written from the requirements.
    function automatic logic [36:0] model(input logic [23:0] a, input logic wr);
        logic [11:0] pg, s, e, o;
        logic [13:0] cp;
        pg = a[23:12];
        for (int w = 0; w < NW; w++) begin
            s = {img[w*8+1][3:0], img[w*8+0]};
            e = {img[w*8+3][3:0], img[w*8+2]};
            o = {img[w*8+5][3:0], img[w*8+4]};
            if (win_en[w] && s <= pg && pg <= e) begin
                cp = {2'b00, pg} + {2'b00, o};
                return {1'b1, 3'(w), cp, a[11:0],
                        img[w*8+1][7], img[w*8+1][6], img[w*8+3][7:6], img[w*8+5][6],
                        wr & img[w*8+5][7], wr & ~img[w*8+5][7]};
            end
        end
        return '0;
    endfunction

    task automatic set_win(input int w, input logic [11:0] s, input logic [11:0] e,
                           input logic [11:0] o, input logic d16, input logic zws,
                           input logic [1:0] wt, input logic at, input logic wp,
                           input logic junk);
        @(negedge clk);
        cyc_vld = 1'b0;
        img[w*8+0] = s[7:0];
        img[w*8+1] = {d16, zws, junk, junk, s[11:8]};
        img[w*8+2] = e[7:0];
        img[w*8+3] = {wt, ~junk, junk, e[11:8]};
        img[w*8+4] = o[7:0];
        img[w*8+5] = {wp, at, junk, ~junk, o[11:8]};
        img[w*8+6] = junk ? 8'hA5 : 8'h00;
        img[w*8+7] = junk ? 8'h5A : 8'h00;
    endtask

    task automatic issue(input logic [23:0] a, input logic wr, input string tag);
        item_t it;
        @(negedge clk);
        cyc_vld   = 1'b1;
        host_addr = a;
        host_wr   = wr;
        it.v   = model(a, wr);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_vld = 1'b0;
            host_addr = 24'hFFFFFF;
            host_wr = 1'b1;
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: results due one clock after the cycle was driven.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_vld) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7 unexpected result actual=%h expected=none", actual());
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (actual() !== it.v) begin
                        n_bad++;
                        $display("FAIL %s actual=%h expected=%h", it.tag, actual(), it.v);
                    end
                end
            end else if (actual() !== '0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R7 idle outputs actual=%h expected=%h", actual(), 37'h0);
            end
        end
    end

    initial begin
        #(8ns * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        rst = 1'b1; cyc_vld = 1'b1; host_addr = 24'h100000; host_wr = 1'b1;
        win_en = '1;
        for (int i = 0; i < NB; i++) img[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (out_vld !== 1'b0 || actual() !== '0) begin
            n_bad++;
            $display("FAIL R8 reset state actual=%b/%h expected=0/%h", out_vld, actual(), 37'h0);
        end
        cyc_vld = 1'b0;
        rst = 1'b0;
        mon_on = 1'b1;

        set_win(0, 12'h100, 12'h1FF, 12'h200, 1, 0, 2'd2, 0, 0, 0);
        set_win(1, 12'h180, 12'h2FF, 12'hF00, 0, 1, 2'd1, 1, 1, 0);
        set_win(2, 12'h800, 12'h7FF, 12'h010, 1, 1, 2'd3, 1, 0, 0);
        set_win(3, 12'h000, 12'hFFF, 12'h001, 0, 0, 2'd3, 0, 0, 1);
        set_win(4, 12'hA00, 12'hA00, 12'h123, 1, 0, 2'd3, 0, 0, 1);
        @(negedge clk);
        win_en = 5'b10111;

        issue(24'h100000, 0, "R1 lower bound");
        issue(24'h1FFFFF, 0, "R1 upper bound");
        issue(24'h180ABC, 0, "R3 overlap lowest wins");
        issue(24'h250123, 0, "R4 window1 attributes");
        issue(24'h250456, 1, "R5 protected write blocked");
        issue(24'h1234CD, 1, "R5 unprotected write enable");
        issue(24'h0FF000, 0, "R9 disabled window no hit");
        issue(24'h300000, 1, "R6 miss all zero");
        issue(24'h800777, 0, "R10 empty window no hit");
        issue(24'hA00FFF, 1, "R2 offset add and R9 junk ignored");
        issue(24'hA01000, 0, "R1 past single page");
        idle(3);
        issue(24'h2FFFFF, 1, "R5 protected at upper edge");
        idle(1);
        issue(24'hFFF000, 0, "R6 top of space miss");

        @(negedge clk);
        cyc_vld = 1'b0;
        win_en = 5'b11111;
        issue(24'h0FF000, 1, "R9 enabled window now hits");
        issue(24'hA00800, 0, "R3 lower window takes priority");
        issue(24'h150000, 0, "R3 window0 before window3");

        set_win(0, 12'hFFF, 12'hFFF, 12'hFFF, 0, 1, 2'd0, 1, 1, 0);
        issue(24'hFFF321, 0, "R2 largest page sum");
        issue(24'hFFF321, 1, "R5 write to protected window0");
        issue(24'h123456, 0, "R4 window3 attributes");
        idle(4);

        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 results outstanding actual=%0d expected=0", q.size());
        end
        report();
    end

endmodule